// File: doc/BRIEF.md
# Dependence-Based Cluster Steering Logic

This block sits after register renaming in a clustered out-of-order core. Every cycle it takes at most one renamed instruction and picks the execution cluster that will receive it. An instruction carries up to two physical source tags and one physical destination tag. The choice tries to place a consumer in the cluster that produces its operands, so that the value does not have to cross the slow bus between clusters. When the operands point at different clusters, or when there are no operands, the block uses the per-cluster issue-queue occupancy supplied by the surrounding core to find the least-loaded cluster.

The block keeps one entry per physical register. Each entry holds the cluster that produces the register, a bit that shows whether the value has reached every cluster, and an allocation stamp that orders producers by age. When a destination is allocated, its entry takes the chosen cluster, its bit is cleared and it gets a new stamp. A writeback event sets the bit again after a configurable inter-cluster delay. A mode input selects between plain dependence steering and readiness-aware steering. Readiness-aware steering stops treating an operand as a constraint once its value is visible in every cluster.

Top module: `cluster_steer`

## Requirements
- R1: An instruction with neither source marked valid is sent to the cluster with the smallest occupancy. Cluster k's occupancy is `queueOcc[k*OCC_W +: OCC_W]`. Ties go to the lowest cluster index. This holds in both modes.
- R2: In plain mode (`steerMode`=0), an instruction with exactly one valid source goes to that source's producer cluster. The tag of the invalid source has no effect.
- R3: In plain mode, when both sources are valid and share one producer cluster, the instruction goes to that cluster whatever the occupancies are.
- R4: In plain mode, when both sources are valid with different producer clusters, the instruction goes to whichever of those two clusters has the smaller occupancy. If the two are equal it goes to the lower index. Other clusters are never chosen.
- R5: In readiness mode (`steerMode`=1), when every valid source is globally ready, the instruction goes to the least-loaded cluster of all, with ties going to the lowest index.
- R6: In readiness mode, when some valid source is not globally ready, the instruction goes to the producer cluster of the youngest valid source. The youngest source is the one whose destination allocation happened most recently. On equal age, source 0 wins.
- R7: A writeback presented in cycle w makes that register globally ready for an instruction presented in cycle w+XLAT. An instruction presented in cycle w+XLAT-1 still sees it not ready.
- R8: An instruction with `dstValid` records its chosen cluster as the destination's producer and clears the destination's ready bit. An instruction presented in the next cycle sees both changes. A ready release that lands in the same cycle as the allocation is overridden by the allocation.
- R9: `steerValid` and `steerCluster` are registered. They show the decision for an instruction one clock after it is presented, and `steerValid` is 0 in any cycle that follows a cycle without an instruction.
- R10: After reset, `steerValid` is 0, every register's producer is cluster 0 and every register is globally ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| steerMode | input | 1 | 0 = plain dependence steering, 1 = readiness-aware steering |
| instValid | input | 1 | An instruction is presented this cycle |
| src0Valid | input | 1 | Source 0 tag is a real register operand |
| src0Tag | input | TAG_W | Physical tag of source 0 |
| src1Valid | input | 1 | Source 1 tag is a real register operand |
| src1Tag | input | TAG_W | Physical tag of source 1 |
| dstValid | input | 1 | The instruction allocates a destination |
| dstTag | input | TAG_W | Physical tag of the destination |
| queueOcc | input | NUM_CLUSTERS*OCC_W | Issue-queue occupancy per cluster, cluster k at bits k*OCC_W upward |
| wbValid | input | 1 | A writeback event occurs this cycle |
| wbTag | input | TAG_W | Physical tag written back |
| steerValid | output | 1 | Registered: a decision is being reported |
| steerCluster | output | CL_W | Registered: chosen cluster index |

## Verification
The cluster decision for an instruction presented in one cycle appears on `steerCluster` after the next rising edge. The bench therefore drives every instruction on a falling edge and reads the result on the following falling edge, half a period after the register has loaded. Table updates from allocation are visible to an instruction presented in the very next cycle. A writeback becomes visible exactly XLAT cycles after its own cycle. The bench probes the cycles just before and at that point with back-to-back instructions that allocate nothing, so that only the release can change the result.

// File: rtl/steer_pkg.sv
package steer_pkg;

  typedef enum logic {
    STEER_PLAIN = 1'b0,
    STEER_READY = 1'b1
  } steerMode_e;

  // strobes from decision control into the table datapath
  typedef struct packed {
    logic issueEn;   // an instruction is being steered this cycle
    logic allocEn;   // it also allocates a destination register
  } steerStrobe_t;

endpackage

// File: rtl/steer_table.sv
module steer_table
  import steer_pkg::*;
#(
  parameter int NUM_CLUSTERS = 4,
  parameter int PREGS        = 64,
  parameter int XLAT         = 3,
  parameter int SEQ_W        = 8,
  localparam int CL_W        = $clog2(NUM_CLUSTERS),
  localparam int TAG_W       = $clog2(PREGS)
) (
  input  logic               clk,
  input  logic               rstN,
  input  steerStrobe_t       strb,
  input  logic [TAG_W-1:0]   allocTag,
  input  logic [CL_W-1:0]    allocCluster,
  input  logic               wbValid,
  input  logic [TAG_W-1:0]   wbTag,
  input  logic [TAG_W-1:0]   rdTag0,
  input  logic [TAG_W-1:0]   rdTag1,
  output logic [CL_W-1:0]    rdProd0,
  output logic [CL_W-1:0]    rdProd1,
  output logic               rdReady0,
  output logic               rdReady1,
  output logic [SEQ_W-1:0]   rdAge0,
  output logic [SEQ_W-1:0]   rdAge1,
  output logic               steerValid,
  output logic [CL_W-1:0]    steerCluster
);

  logic [CL_W-1:0]  prodQ  [PREGS];
  logic             readyQ [PREGS];
  logic [SEQ_W-1:0] stampQ [PREGS];
  logic [SEQ_W-1:0] seqQ;

  logic             relValid;
  logic [TAG_W-1:0] relTag;

  // writeback-to-global-ready delay, one variant per latency
  generate
    if (XLAT <= 1) begin : g_direct
      assign relValid = wbValid;
      assign relTag   = wbTag;
    end else begin : g_pipe
      logic             pipeV [XLAT-1];
      logic [TAG_W-1:0] pipeT [XLAT-1];
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          for (int i = 0; i < XLAT-1; i++) begin
            pipeV[i] <= 1'b0;
            pipeT[i] <= '0;
          end
        end else begin
          pipeV[0] <= wbValid;
          pipeT[0] <= wbTag;
          for (int i = 1; i < XLAT-1; i++) begin
            pipeV[i] <= pipeV[i-1];
            pipeT[i] <= pipeT[i-1];
          end
        end
      end
      assign relValid = pipeV[XLAT-2];
      assign relTag   = pipeT[XLAT-2];
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int r = 0; r < PREGS; r++) begin
        prodQ[r]  <= '0;
        readyQ[r] <= 1'b1;
        stampQ[r] <= '0;
      end
      seqQ <= SEQ_W'(1);
    end else begin
      if (relValid) readyQ[relTag] <= 1'b1;
      // allocation comes second so it overrides a same-cycle release
      if (strb.allocEn) begin
        readyQ[allocTag] <= 1'b0;
        prodQ[allocTag]  <= allocCluster;
        stampQ[allocTag] <= seqQ;
        seqQ             <= seqQ + SEQ_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      steerValid   <= 1'b0;
      steerCluster <= '0;
    end else begin
      steerValid <= strb.issueEn;
      if (strb.issueEn) steerCluster <= allocCluster;
    end
  end

  assign rdProd0  = prodQ[rdTag0];
  assign rdProd1  = prodQ[rdTag1];
  assign rdReady0 = readyQ[rdTag0];
  assign rdReady1 = readyQ[rdTag1];
  assign rdAge0   = seqQ - stampQ[rdTag0];
  assign rdAge1   = seqQ - stampQ[rdTag1];

  assert_alloc_clears_ready_R8: assert property (@(posedge clk) disable iff (!rstN)
    strb.allocEn |=> !readyQ[$past(allocTag)]);

  assert_alloc_records_prod_R8: assert property (@(posedge clk) disable iff (!rstN)
    strb.allocEn |=> prodQ[$past(allocTag)] == $past(allocCluster));

endmodule

// File: rtl/steer_ctrl.sv
module steer_ctrl
  import steer_pkg::*;
#(
  parameter int NUM_CLUSTERS = 4,
  parameter int OCC_W        = 5,
  parameter int SEQ_W        = 8,
  localparam int CL_W        = $clog2(NUM_CLUSTERS)
) (
  input  steerMode_e                    mode,
  input  logic                          instValid,
  input  logic                          src0Valid,
  input  logic                          src1Valid,
  input  logic                          dstValid,
  input  logic [NUM_CLUSTERS*OCC_W-1:0] queueOcc,
  input  logic [CL_W-1:0]               prod0,
  input  logic [CL_W-1:0]               prod1,
  input  logic                          ready0,
  input  logic                          ready1,
  input  logic [SEQ_W-1:0]              age0,
  input  logic [SEQ_W-1:0]              age1,
  output steerStrobe_t                  strb,
  output logic [CL_W-1:0]               chosen
);

  logic [OCC_W-1:0] occ [NUM_CLUSTERS];
  logic [CL_W-1:0]  leastAll;
  logic [CL_W-1:0]  leastPair;
  logic [CL_W-1:0]  youngProd;
  logic             allReady;

  generate
    for (genvar k = 0; k < NUM_CLUSTERS; k++) begin : g_occ
      assign occ[k] = queueOcc[k*OCC_W +: OCC_W];
    end
  endgenerate

  // least-loaded over all clusters, first index wins ties
  always_comb begin
    leastAll = '0;
    for (int k = 1; k < NUM_CLUSTERS; k++)
      if (occ[k] < occ[leastAll]) leastAll = CL_W'(k);
  end

  // least-loaded of the two producer clusters
  always_comb begin
    if (occ[prod1] < occ[prod0])      leastPair = prod1;
    else if (occ[prod0] < occ[prod1]) leastPair = prod0;
    else                              leastPair = (prod1 < prod0) ? prod1 : prod0;
  end

  always_comb begin
    allReady = (!src0Valid || ready0) && (!src1Valid || ready1);
    if (src0Valid && src1Valid) youngProd = (age1 < age0) ? prod1 : prod0;
    else if (src1Valid)         youngProd = prod1;
    else                        youngProd = prod0;
  end

  always_comb begin
    if (!src0Valid && !src1Valid) begin
      chosen = leastAll;
    end else if (mode == STEER_READY) begin
      chosen = allReady ? leastAll : youngProd;
    end else if (src0Valid && src1Valid) begin
      chosen = (prod0 == prod1) ? prod0 : leastPair;
    end else begin
      chosen = src0Valid ? prod0 : prod1;
    end
  end

  assign strb.issueEn = instValid;
  assign strb.allocEn = instValid && dstValid;

endmodule

// File: rtl/cluster_steer.sv
module cluster_steer
  import steer_pkg::*;
#(
  parameter int NUM_CLUSTERS = 4,
  parameter int PREGS        = 64,
  parameter int OCC_W        = 5,
  parameter int XLAT         = 3,
  parameter int SEQ_W        = 8,
  localparam int CL_W        = $clog2(NUM_CLUSTERS),
  localparam int TAG_W       = $clog2(PREGS)
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          steerMode,
  input  logic                          instValid,
  input  logic                          src0Valid,
  input  logic [TAG_W-1:0]              src0Tag,
  input  logic                          src1Valid,
  input  logic [TAG_W-1:0]              src1Tag,
  input  logic                          dstValid,
  input  logic [TAG_W-1:0]              dstTag,
  input  logic [NUM_CLUSTERS*OCC_W-1:0] queueOcc,
  input  logic                          wbValid,
  input  logic [TAG_W-1:0]              wbTag,
  output logic                          steerValid,
  output logic [CL_W-1:0]               steerCluster
);

  steerStrobe_t      strb;
  logic [CL_W-1:0]   chosen;
  logic [CL_W-1:0]   prod0, prod1;
  logic              ready0, ready1;
  logic [SEQ_W-1:0]  age0, age1;
  steerMode_e        mode;

  assign mode = steerMode_e'(steerMode);

  steer_ctrl #(.NUM_CLUSTERS(NUM_CLUSTERS), .OCC_W(OCC_W), .SEQ_W(SEQ_W)) ctrl_i (
    .mode(mode), .instValid(instValid), .src0Valid(src0Valid), .src1Valid(src1Valid),
    .dstValid(dstValid), .queueOcc(queueOcc), .prod0(prod0), .prod1(prod1),
    .ready0(ready0), .ready1(ready1), .age0(age0), .age1(age1),
    .strb(strb), .chosen(chosen)
  );

  steer_table #(.NUM_CLUSTERS(NUM_CLUSTERS), .PREGS(PREGS), .XLAT(XLAT), .SEQ_W(SEQ_W)) table_i (
    .clk(clk), .rstN(rstN), .strb(strb), .allocTag(dstTag), .allocCluster(chosen),
    .wbValid(wbValid), .wbTag(wbTag), .rdTag0(src0Tag), .rdTag1(src1Tag),
    .rdProd0(prod0), .rdProd1(prod1), .rdReady0(ready0), .rdReady1(ready1),
    .rdAge0(age0), .rdAge1(age1), .steerValid(steerValid), .steerCluster(steerCluster)
  );

  assert_valid_follows_R9: assert property (@(posedge clk) disable iff (!rstN)
    instValid |=> steerValid);

  assert_idle_follows_R9: assert property (@(posedge clk) disable iff (!rstN)
    !instValid |=> !steerValid);

  assert_single_src_R2: assert property (@(posedge clk) disable iff (!rstN)
    (instValid && !steerMode && (src0Valid ^ src1Valid))
      |=> steerCluster == $past(src0Valid ? prod0 : prod1));

  assert_shared_prod_R3: assert property (@(posedge clk) disable iff (!rstN)
    (instValid && !steerMode && src0Valid && src1Valid && prod0 == prod1)
      |=> steerCluster == $past(prod0));

  assert_pair_only_R4: assert property (@(posedge clk) disable iff (!rstN)
    (instValid && !steerMode && src0Valid && src1Valid)
      |=> (steerCluster == $past(prod0)) || (steerCluster == $past(prod1)));

endmodule

// File: tb/cluster_steer_tb.sv
module cluster_steer_tb_top;

  localparam int NC = 4;
  localparam int OW = 5;

  logic        clk = 1'b0;
  logic        rstN;
  logic        steerMode, instValid, src0Valid, src1Valid, dstValid, wbValid;
  logic [5:0]  src0Tag, src1Tag, dstTag, wbTag;
  logic [NC*OW-1:0] queueOcc;
  logic        steerValid;
  logic [1:0]  steerCluster;

  int vecs = 0;
  int miscmp = 0;

  always #10 clk = ~clk;

  cluster_steer #(.NUM_CLUSTERS(NC), .PREGS(64), .OCC_W(OW), .XLAT(3), .SEQ_W(8)) dut_i (
    .clk(clk), .rstN(rstN), .steerMode(steerMode), .instValid(instValid),
    .src0Valid(src0Valid), .src0Tag(src0Tag), .src1Valid(src1Valid), .src1Tag(src1Tag),
    .dstValid(dstValid), .dstTag(dstTag), .queueOcc(queueOcc),
    .wbValid(wbValid), .wbTag(wbTag), .steerValid(steerValid), .steerCluster(steerCluster)
  );

  function automatic logic [NC*OW-1:0] occ4(input int c0, input int c1, input int c2, input int c3);
    return {OW'(c3), OW'(c2), OW'(c1), OW'(c0)};
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    vecs++;
    if (act != exp) begin
      miscmp++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // drive at a falling edge, read the registered decision one edge later
  task automatic issue(input logic md, input logic v0, input int t0, input logic v1, input int t1,
                       input logic dv, input int dt, input logic [NC*OW-1:0] occ,
                       input int exp, input string req);
    steerMode = md; instValid = 1'b1;
    src0Valid = v0; src0Tag = 6'(t0);
    src1Valid = v1; src1Tag = 6'(t1);
    dstValid = dv;  dstTag = 6'(dt);
    queueOcc = occ;
    @(negedge clk);
    chk({req, " valid"}, int'(steerValid), 1);
    chk(req, int'(steerCluster), exp);
    instValid = 1'b0; dstValid = 1'b0; src0Valid = 1'b0; src1Valid = 1'b0;
  endtask

  task automatic writeback(input int t);
    wbValid = 1'b1; wbTag = 6'(t);
    @(negedge clk);
    wbValid = 1'b0;
  endtask

  task automatic t_reset_state;
    chk("R10 steerValid after reset", int'(steerValid), 0);
    issue(1'b0, 1'b1, 5, 1'b0, 0, 1'b0, 0, occ4(9, 9, 1, 9), 0, "R10 reset producer is 0");
    issue(1'b1, 1'b1, 5, 1'b0, 0, 1'b0, 0, occ4(9, 9, 1, 9), 2, "R10 reset reg is ready");
  endtask

  task automatic t_no_sources;
    issue(1'b0, 1'b0, 7, 1'b0, 9, 1'b0, 0, occ4(7, 3, 3, 9), 1, "R1 tie to lower index");
    issue(1'b1, 1'b0, 7, 1'b0, 9, 1'b0, 0, occ4(4, 4, 4, 4), 0, "R1 all equal");
    issue(1'b1, 1'b0, 0, 1'b0, 0, 1'b0, 0, occ4(9, 8, 7, 2), 3, "R1 last cluster");
  endtask

  task automatic t_alloc_and_single;
    issue(1'b0, 1'b0, 0, 1'b0, 0, 1'b1, 10, occ4(5, 5, 5, 1), 3, "R8 alloc reg10");
    issue(1'b0, 1'b1, 10, 1'b0, 0, 1'b0, 0, occ4(0, 9, 9, 9), 3, "R2 R8 src0 sees producer");
    issue(1'b0, 1'b0, 0, 1'b1, 10, 1'b0, 0, occ4(0, 9, 9, 9), 3, "R2 src1 only");
    issue(1'b0, 1'b0, 0, 1'b0, 0, 1'b1, 11, occ4(6, 0, 6, 6), 1, "R8 alloc reg11");
    issue(1'b0, 1'b0, 0, 1'b0, 0, 1'b1, 12, occ4(6, 0, 6, 6), 1, "R8 alloc reg12");
  endtask

  task automatic t_plain_pairs;
    issue(1'b0, 1'b1, 11, 1'b1, 12, 1'b0, 0, occ4(0, 20, 0, 0), 1, "R3 shared producer");
    issue(1'b0, 1'b1, 10, 1'b1, 11, 1'b0, 0, occ4(0, 5, 0, 2), 3, "R4 pick c3");
    issue(1'b0, 1'b1, 10, 1'b1, 11, 1'b0, 0, occ4(0, 2, 0, 5), 1, "R4 pick c1");
    issue(1'b0, 1'b1, 10, 1'b1, 11, 1'b0, 0, occ4(0, 4, 0, 4), 1, "R4 tie lower");
    issue(1'b0, 1'b1, 11, 1'b1, 10, 1'b0, 0, occ4(0, 4, 0, 4), 1, "R4 tie swapped");
  endtask

  task automatic t_youngest;
    issue(1'b1, 1'b1, 10, 1'b1, 12, 1'b0, 0, occ4(0, 9, 9, 9), 1, "R6 younger src1");
    issue(1'b1, 1'b1, 12, 1'b1, 10, 1'b0, 0, occ4(0, 9, 9, 9), 1, "R6 younger src0");
    issue(1'b1, 1'b0, 0, 1'b0, 0, 1'b1, 13, occ4(9, 9, 0, 9), 2, "R8 alloc reg13");
    issue(1'b1, 1'b1, 13, 1'b1, 11, 1'b0, 0, occ4(0, 9, 9, 9), 2, "R6 newest reg13");
    issue(1'b1, 1'b1, 11, 1'b1, 10, 1'b0, 0, occ4(0, 9, 9, 9), 1, "R6 reg11 over reg10");
    issue(1'b1, 1'b1, 5, 1'b1, 10, 1'b0, 0, occ4(0, 9, 9, 9), 3, "R6 ready reg5 older");
    issue(1'b1, 1'b0, 0, 1'b1, 13, 1'b0, 0, occ4(0, 9, 9, 9), 2, "R6 single pending");
  endtask

  task automatic t_release_timing;
    writeback(10);
    issue(1'b1, 1'b1, 10, 1'b0, 0, 1'b0, 0, occ4(0, 9, 9, 9), 3, "R7 w+1 not ready");
    issue(1'b1, 1'b1, 10, 1'b0, 0, 1'b0, 0, occ4(0, 9, 9, 9), 3, "R7 w+2 not ready");
    issue(1'b1, 1'b1, 10, 1'b0, 0, 1'b0, 0, occ4(0, 9, 9, 9), 0, "R7 w+3 ready");
  endtask

  task automatic t_all_ready;
    writeback(12);
    @(negedge clk);
    @(negedge clk);
    issue(1'b1, 1'b1, 10, 1'b1, 12, 1'b0, 0, occ4(3, 6, 0, 9), 2, "R5 both ready");
    issue(1'b0, 1'b1, 10, 1'b1, 12, 1'b0, 0, occ4(3, 6, 0, 9), 1, "R4 plain ignores ready");
    issue(1'b1, 1'b1, 10, 1'b1, 13, 1'b0, 0, occ4(0, 9, 9, 9), 2, "R6 one pending");
  endtask

  task automatic t_alloc_override;
    writeback(14);
    issue(1'b0, 1'b0, 0, 1'b0, 0, 1'b0, 0, occ4(1, 1, 1, 1), 0, "R1 filler");
    issue(1'b0, 1'b0, 0, 1'b0, 0, 1'b1, 14, occ4(9, 0, 9, 9), 1, "R8 alloc reg14");
    issue(1'b1, 1'b1, 14, 1'b0, 0, 1'b0, 0, occ4(0, 9, 9, 9), 1, "R8 alloc beats release");
    @(negedge clk);
    chk("R9 idle cycle", int'(steerValid), 0);
  endtask

  initial begin
    rstN = 1'b0; steerMode = 1'b0; instValid = 1'b0; src0Valid = 1'b0; src1Valid = 1'b0;
    dstValid = 1'b0; wbValid = 1'b0; src0Tag = '0; src1Tag = '0; dstTag = '0; wbTag = '0;
    queueOcc = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset_state();
    t_no_sources();
    t_alloc_and_single();
    t_plain_pairs();
    t_youngest();
    t_release_timing();
    t_all_ready();
    t_alloc_override();
    $display("== %0d vectors applied, %0d miscompares ==", vecs, miscmp);
    $finish;
  end

  initial begin
    #(20 * 200000);
    miscmp++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, miscmp);
    $finish;
  end

endmodule